// File: doc/BRIEF.md
# TLP Beat Packer

This block converts a PCI Express transaction layer packet, presented as a stream of 32-bit words, into a wide streaming bus. The input carries one word per cycle under a valid/ready handshake, with a flag on the final word of each packet. Each input word holds four consecutive packet bytes, the earliest of them in bits [7:0]. The first three or four words form the header. The words after them form the payload.

Header words and payload words are laid out differently on the output. A header word is byte-reversed, so its earliest byte lands in the top lane of the word. A payload word keeps its earliest byte in the bottom lane. The payload follows the header with no gap. The output groups words into beats of `LANES` word slots and marks the first beat, the last beat and the count of unused slots in the last beat. The same layout serves the transmit direction and, read in reverse, the receive direction.

Top module: `tlp_beat_packer`

## Requirements
- R1: For a header word holding stream bytes 4k..4k+3 (input bits [7:0] = byte 4k), the output slot holds byte 4k in bits [31:24], byte 4k+1 in [23:16], byte 4k+2 in [15:8] and byte 4k+3 in [7:0].
- R2: A payload word leaves the block unchanged: stream byte 4n stays in bits [7:0] and byte 4n+3 stays in bits [31:24].
- R3: Bit 5 of the first input word of a packet selects the header length: 1 means four header words and 0 means three. Only those words receive the R1 ordering.
- R4: The first payload word occupies the slot right after the last header word (slot 3 or slot 4 of the first beat). No padding slot is inserted.
- R5: Word slot i of a beat occupies out_data bits [32i+31:32i]. Words fill the slots in arrival order, and a packet longer than `LANES` words spans several beats.
- R6: out_sop is high only on the first beat of a packet, and out_eop only on its last beat. out_empty gives the number of unused slots on the last beat and is 0 on every other beat. Unused slots read as zero.
- R7: Every packet starts at slot 0 of a fresh beat, so two packets never share a beat.
- R8: While out_valid is high and out_ready is low, out_valid, out_data, out_sop, out_eop and out_empty hold their values, and no input word is lost.
- R9: While out_ready stays high, in_ready stays high, so the block takes one word every cycle.
- R10: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 32 | Four stream bytes, earliest in bits [7:0] |
| in_last | input | 1 | Final word of the packet |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | LANES*32 | Beat of word slots, slot 0 in the low bits |
| out_sop | output | 1 | Beat carries the first header word |
| out_eop | output | 1 | Beat carries the final word |
| out_empty | output | $clog2(LANES) | Unused slots on the final beat |

## Verification
The bench builds the block with the default LANES of 8. With that width, a three-word header plus five payload words fills exactly one beat. A bare three-word header leaves five empty slots, and a seventeen-word packet spans three beats with seven empty slots. A reference packer in the bench derives the expected beats from the stream bytes under three downstream patterns: always ready, irregular ready, and long back-pressure.

// File: rtl/tlp_beat_packer.sv
module tlp_beat_packer #(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [31:0]           in_data,
  input  logic                  in_last,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES*32-1:0]   out_data,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [((LANES>1)?$clog2(LANES):1)-1:0] out_empty
);
  localparam int EW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [EW-1:0] TOP = EW'(LANES - 1);

  logic [LANES*32-1:0] asm_data, asm_next;
  logic [EW-1:0]       asm_cnt, asm_empty;
  logic                asm_sop, asm_eop, asm_full;
  logic [2:0]          pos;
  logic                hdr4, cur_hdr4, is_hdr, first;
  logic                out_free, move, take, beat_done;
  logic [31:0]         word;

  assign out_free  = !out_valid || out_ready;
  assign move      = asm_full && out_free;
  assign in_ready  = !asm_full || out_free;
  assign take      = in_valid && in_ready;
  assign first     = (pos == 3'd0);
  assign cur_hdr4  = first ? in_data[5] : hdr4;
  assign is_hdr    = (pos < 3'd3) || (pos == 3'd3 && cur_hdr4);
  assign word      = is_hdr ? {in_data[7:0], in_data[15:8], in_data[23:16], in_data[31:24]}
                            : in_data;
  assign beat_done = (asm_cnt == TOP) || in_last;

  always_comb begin
    asm_next = move ? '0 : asm_data;
    if (take) asm_next[int'(asm_cnt)*32 +: 32] = word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      hdr4 <= 1'b0;
    end else if (take) begin
      if (first) hdr4 <= in_data[5];
      if (in_last)              pos <= '0;
      else if (pos != 3'd4)     pos <= pos + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_data  <= '0;
      asm_cnt   <= '0;
      asm_sop   <= 1'b0;
      asm_eop   <= 1'b0;
      asm_empty <= '0;
      asm_full  <= 1'b0;
    end else begin
      asm_data <= asm_next;
      if (take) begin
        if (asm_cnt == '0) asm_sop <= first;
        if (beat_done) begin
          asm_full  <= 1'b1;
          asm_cnt   <= '0;
          asm_eop   <= in_last;
          asm_empty <= TOP - asm_cnt;
        end else begin
          asm_full  <= 1'b0;
          asm_cnt   <= asm_cnt + 1'b1;
        end
      end else if (move) begin
        asm_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_empty <= '0;
    end else if (move) begin
      out_valid <= 1'b1;
      out_data  <= asm_data;
      out_sop   <= asm_sop;
      out_eop   <= asm_eop;
      out_empty <= asm_eop ? asm_empty : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
                                && $stable(out_eop) && $stable(out_empty));

  p_empty_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eop |-> out_empty == '0);

  p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop |-> (out_data >> ((LANES - int'(out_empty)) * 32)) == '0);

  p_tput_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: tb/tlp_beat_packer_test.sv
module tlp_beat_packer_test;
  localparam int LANES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [LANES*32-1:0] out_data;
  logic [2:0] out_empty;

  always #10 clk = ~clk;

  tlp_beat_packer #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_empty(out_empty));

  int errors = 0, checks = 0, stalls = 0, cyc = 0, ready_mode = 0;
  string tag = "R1 R2 R4 R5";
  logic [32:0] inq[$];
  logic [LANES*32-1:0] exp_d[$];
  logic exp_s[$], exp_e[$];
  logic [2:0] exp_m[$];
  bit took_in = 0, hold_pending = 0, done = 0;
  logic [LANES*32-1:0] snap_d;
  logic snap_s, snap_e;
  logic [2:0] snap_m;

  task automatic chk(bit ok, string req, string what, logic [LANES*32-1:0] act, logic [LANES*32-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic add_pkt(bit h4, int ndata, int seed);
    int hl = h4 ? 4 : 3;
    int n = hl + ndata;
    int slot = 0;
    bit sop = 1;
    logic [LANES*32-1:0] beat = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w, od;
      for (int j = 0; j < 4; j++) w[8*j +: 8] = 8'((seed + 4*i + j) & 8'hff);
      if (i == 0) begin w[5] = h4; w[6] = (ndata > 0); end
      od = (i < hl) ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
      beat[slot*32 +: 32] = od;
      slot++;
      inq.push_back({(i == n-1), w});
      if (slot == LANES || i == n-1) begin
        exp_d.push_back(beat);
        exp_s.push_back(sop);
        exp_e.push_back(i == n-1);
        exp_m.push_back((i == n-1) ? 3'((LANES - slot) % LANES) : 3'd0);
        sop = 0; beat = '0; slot = 0;
      end
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 5000 && (inq.size() != 0 || exp_d.size() != 0); k++) @(posedge clk);
    chk(inq.size() == 0 && exp_d.size() == 0, "R8", "all beats delivered", exp_d.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (took_in) void'(inq.pop_front());
      in_valid = inq.size() != 0;
      {in_last, in_data} = in_valid ? inq[0] : 33'd0;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = cyc[0] ^ cyc[2] ^ cyc[4];
        default: out_ready = (cyc % 9) == 8;
      endcase
      #5;
      if (hold_pending)
        chk(out_valid && out_data == snap_d && out_sop == snap_s && out_eop == snap_e && out_empty == snap_m,
            "R8", "outputs held under back-pressure", out_data, snap_d);
      hold_pending = out_valid && !out_ready;
      snap_d = out_data; snap_s = out_sop; snap_e = out_eop; snap_m = out_empty;
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) chk(0, "R6", "unexpected beat", out_data, 0);
        else begin
          chk(out_data == exp_d[0], tag, "beat data", out_data, exp_d[0]);
          chk(out_sop == exp_s[0], "R6 R7", "sop", out_sop, exp_s[0]);
          chk(out_eop == exp_e[0] && out_empty == exp_m[0], "R6", "eop/empty",
              {out_eop, out_empty}, {exp_e[0], exp_m[0]});
          void'(exp_d.pop_front()); void'(exp_s.pop_front());
          void'(exp_e.pop_front()); void'(exp_m.pop_front());
        end
      end
      if (ready_mode == 0 && in_valid && !in_ready) stalls++;
      took_in = in_valid && in_ready;
    end
  end

  task automatic t_reset();
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_shapes();
    ready_mode = 0; tag = "R1 R5 R6";
    add_pkt(0, 0, 8'h10); drain();
    tag = "R1 R2 R5";
    add_pkt(1, 4, 8'h40); drain();
    tag = "R4 no gap after 3-word header";
    add_pkt(0, 6, 8'h80); drain();
    tag = "R5 multi-beat";
    add_pkt(1, 13, 8'hA3); drain();
  endtask

  task automatic t_hdr_len();
    ready_mode = 0; tag = "R3 header length select";
    add_pkt(1, 3, 8'h21); drain();
    add_pkt(0, 4, 8'h21); drain();
  endtask

  task automatic t_throughput();
    ready_mode = 0; stalls = 0; tag = "R7 back-to-back";
    add_pkt(0, 1, 8'h05); add_pkt(1, 9, 8'h33); add_pkt(0, 0, 8'h61);
    add_pkt(1, 0, 8'h77); add_pkt(0, 5, 8'h90);
    drain();
    chk(stalls == 0, "R9", "input stall cycles with ready high", stalls, 0);
  endtask

  task automatic t_backpressure();
    ready_mode = 2; tag = "R8 back-pressure";
    add_pkt(1, 12, 8'h11); add_pkt(0, 2, 8'hC0); add_pkt(1, 0, 8'h2E);
    drain();
    ready_mode = 1; tag = "R7 R8 irregular ready";
    for (int p = 0; p < 12; p++) add_pkt(p[0], (p * 5) % 14, 8'(p * 29));
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_shapes();
    t_hdr_len();
    t_throughput();
    t_backpressure();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule